// File: doc/BRIEF.md
# I2C Target Automatic Clock Stretcher

This block decides when an I2C target must hold the SCL line low because its two-byte transmit or receive buffer cannot keep pace with the bus. It synchronizes the raw SCL input and watches for falling edges. At each falling edge it looks at three things: the bit phase reported by the protocol engine, the transfer direction and the fill levels of both buffers. If the target is about to send something it does not yet have, or to acknowledge a byte it has no room for, the block drives a registered, glitch-free open-drain pull-down enable for SCL.

A hold ends in one of two ways. Either the buffer condition clears, or a programmable timeout runs out. A 4-bit mode input turns the feature off and, when it is on, selects a timeout of 2^(N+1) system clocks. A timeout raises a sticky status flag, which a read strobe clears. After a timeout the block waits for the next falling edge of SCL before it can hold again. The protocol engine, start/stop detection and the buffer storage sit outside the block and appear only as inputs.

Top module: `i2c_tgt_autostretch`

## Requirements
- R1: With mode_i equal to 0 (disabled) or 15 (reserved, also disabled), scl_low_en_o never asserts.
- R2: When is_tx_i=1, tx_level_i=00 (empty) and phase_i is 01 (address acknowledge slot comes next) or 10 (data bits come next), scl_low_en_o asserts after the third rising clock edge following the first edge that samples scl_in low. It does not assert for phase 00 or 11, or when the transmit buffer is not empty.
- R3: A transmit hold is released on the first clock edge at which tx_level_i is non-zero, and the status flag is not set.
- R4: When is_tx_i=0, rx_level_i is 10 or the reserved value 11 (full) and phase_i=11 (data acknowledge slot comes next), a hold starts with the same timing as in R2. It does not start for any other phase or for a level below 10.
- R5: A receive hold is released on the first clock edge at which rx_level_i is below 10, and the status flag is not set.
- R6: A hold that is not released by its buffer lasts exactly 2^(N+1) clock cycles. N is the value of mode_i latched when the hold starts, so later changes to mode_i do not affect it. At release, tmo_flag_o is set.
- R7: tmo_flag_o stays set until a cycle in which status_rd_i=1, and it clears on that edge. A timeout on the same edge as the read wins, and the flag stays set.
- R8: After a timeout the block does not hold again while SCL stays low and the buffer stays in its stalled state. The next falling edge of SCL can start a new hold.
- R9: When the buffer condition clears on the same edge at which the timeout would expire, the hold ends without setting tmo_flag_o.
- R10: During and right after reset, scl_low_en_o=0 and tmo_flag_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL level from the pad |
| phase_i | input | 2 | Next bit phase: 00 other, 01 address ACK, 10 data bits, 11 data ACK |
| is_tx_i | input | 1 | 1 when the target transmits |
| tx_level_i | input | 2 | Transmit buffer fill count |
| rx_level_i | input | 2 | Receive buffer fill count |
| mode_i | input | 4 | 0/15 off, 1..14 on with timeout 2^(N+1) clocks |
| status_rd_i | input | 1 | Status read strobe, clears the timeout flag |
| scl_low_en_o | output | 1 | Registered enable for the SCL open-drain pull-down |
| tmo_flag_o | output | 1 | Sticky stretch-timeout flag |

## Verification
The bench builds the block with its default parameters: a 4-bit mode, 2-bit levels, a buffer depth of 2 and two synchronizer stages. With the 4-bit mode, every timeout period from 4 to 32768 clocks can be selected, so the bench covers both the shortest period and the full-length one. The 2-bit levels make the reserved count 11 reachable, and the bench checks that it counts as full. Random trials run the short periods against buffer releases at every possible delay, including the release that falls on the expiry edge itself.

// File: rtl/i2c_ast_pkg.sv
package i2c_ast_pkg;
  typedef enum logic [1:0] {
    PH_OTHER     = 2'b00,
    PH_ADDR_ACK  = 2'b01,
    PH_DATA_BITS = 2'b10,
    PH_DATA_ACK  = 2'b11
  } bit_phase_t;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'b00,
    ST_TX_HOLD = 2'b01,
    ST_RX_HOLD = 2'b10
  } hold_st_t;
endpackage

// File: rtl/ast_scl_sync.sv
module ast_scl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic stage_d;
      if (g == 0) begin : g_first
        assign stage_d = scl_i;
      end else begin : g_next
        assign stage_d = sync_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b1;
        else        sync_q[g] <= stage_d;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= sync_q[STAGES-1];
  end

  assign fall_o = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/ast_trigger.sv
module ast_trigger
  import i2c_ast_pkg::*;
#(
  parameter int MODE_W = 4,
  parameter int LVL_W  = 2,
  parameter int DEPTH  = 2
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic              is_tx_i,
  input  logic [1:0]        phase_i,
  input  logic [LVL_W-1:0]  tx_level_i,
  input  logic [LVL_W-1:0]  rx_level_i,
  output logic              tx_start_o,
  output logic              rx_start_o,
  output logic              tx_clear_o,
  output logic              rx_clear_o
);
  localparam logic [MODE_W-1:0] MODE_OFF = '0;
  localparam logic [MODE_W-1:0] MODE_RSV = '1;
  localparam logic [LVL_W-1:0]  LVL_FULL = LVL_W'(DEPTH);

  logic       enabled;
  logic       tx_empty;
  logic       rx_full;
  bit_phase_t ph;

  always_comb begin
    ph         = bit_phase_t'(phase_i);
    enabled    = (mode_i != MODE_OFF) && (mode_i != MODE_RSV);
    tx_empty   = (tx_level_i == '0);
    rx_full    = (rx_level_i >= LVL_FULL);
    tx_start_o = enabled && is_tx_i && tx_empty &&
                 ((ph == PH_ADDR_ACK) || (ph == PH_DATA_BITS));
    rx_start_o = enabled && !is_tx_i && rx_full && (ph == PH_DATA_ACK);
    tx_clear_o = !tx_empty;
    rx_clear_o = !rx_full;
  end
endmodule

// File: rtl/ast_timer.sv
module ast_timer #(
  parameter int MODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              run_i,
  input  logic [MODE_W-1:0] sel_i,
  output logic              expire_o
);
  localparam int CNT_W = (1 << MODE_W) - 1;

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [MODE_W-1:0] sel_q, sel_d;
  logic [CNT_W-1:0]  lim_m1;

  always_comb begin
    lim_m1 = {CNT_W{1'b1}} >> (CNT_W - 1 - int'(sel_q));
    sel_d  = sel_q;
    cnt_d  = cnt_q;
    if (start_i) begin
      sel_d = sel_i;
      cnt_d = '0;
    end else if (run_i) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
    expire_o = run_i && (cnt_q == lim_m1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sel_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      sel_q <= sel_d;
    end
  end
endmodule

// File: rtl/i2c_tgt_autostretch.sv
module i2c_tgt_autostretch
  import i2c_ast_pkg::*;
#(
  parameter int MODE_W      = 4,
  parameter int LVL_W       = 2,
  parameter int DEPTH       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic [1:0]        phase_i,
  input  logic              is_tx_i,
  input  logic [LVL_W-1:0]  tx_level_i,
  input  logic [LVL_W-1:0]  rx_level_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              status_rd_i,
  output logic              scl_low_en_o,
  output logic              tmo_flag_o
);
  logic     scl_fall;
  logic     tx_start, rx_start, tx_clear, rx_clear;
  logic     expire;
  logic     tmo_evt;
  logic     hold_start;
  hold_st_t st_q, st_d;
  logic     hold_q, hold_d;
  logic     flag_q, flag_d;

  ast_scl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (scl_in),
    .fall_o (scl_fall)
  );

  ast_trigger #(.MODE_W(MODE_W), .LVL_W(LVL_W), .DEPTH(DEPTH)) u_trig (
    .mode_i     (mode_i),
    .is_tx_i    (is_tx_i),
    .phase_i    (phase_i),
    .tx_level_i (tx_level_i),
    .rx_level_i (rx_level_i),
    .tx_start_o (tx_start),
    .rx_start_o (rx_start),
    .tx_clear_o (tx_clear),
    .rx_clear_o (rx_clear)
  );

  ast_timer #(.MODE_W(MODE_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (hold_start),
    .run_i    (hold_q),
    .sel_i    (mode_i),
    .expire_o (expire)
  );

  // Next-state: starts only on an SCL falling edge; buffer release beats timeout.
  always_comb begin
    st_d    = st_q;
    tmo_evt = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (scl_fall && tx_start)      st_d = ST_TX_HOLD;
        else if (scl_fall && rx_start) st_d = ST_RX_HOLD;
      end
      ST_TX_HOLD: begin
        if (tx_clear) begin
          st_d = ST_IDLE;
        end else if (expire) begin
          st_d    = ST_IDLE;
          tmo_evt = 1'b1;
        end
      end
      ST_RX_HOLD: begin
        if (rx_clear) begin
          st_d = ST_IDLE;
        end else if (expire) begin
          st_d    = ST_IDLE;
          tmo_evt = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    hold_start = (st_q == ST_IDLE) && (st_d != ST_IDLE);
    hold_d     = (st_d != ST_IDLE);
    flag_d     = flag_q;
    if (tmo_evt)          flag_d = 1'b1;
    else if (status_rd_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      hold_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      hold_q <= hold_d;
      flag_q <= flag_d;
    end
  end

  assign scl_low_en_o = hold_q;
  assign tmo_flag_o   = flag_q;
endmodule

// File: rtl/i2c_ast_chk.sv
module i2c_ast_chk
  import i2c_ast_pkg::*;
#(
  parameter int MODE_W = 4,
  parameter int LVL_W  = 2,
  parameter int DEPTH  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [MODE_W-1:0] mode_i,
  input logic [LVL_W-1:0]  tx_level_i,
  input logic [LVL_W-1:0]  rx_level_i,
  input logic              status_rd_i,
  input logic              scl_fall,
  input logic              tmo_evt,
  input hold_st_t          st_q,
  input logic              scl_low_en_o,
  input logic              tmo_flag_o
);
  localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);

  AST_OFF_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_low_en_o && (mode_i == '0 || mode_i == '1)) |=> !scl_low_en_o); // R1

  AST_START_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_low_en_o) |-> $past(scl_fall)); // R2

  AST_TX_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TX_HOLD && tx_level_i != '0) |=> (!scl_low_en_o && !$rose(tmo_flag_o))); // R3

  AST_RX_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RX_HOLD && rx_level_i < LVL_FULL) |=> (!scl_low_en_o && !$rose(tmo_flag_o))); // R5

  AST_TMO_ENDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag_o) |-> ($past(scl_low_en_o) && !scl_low_en_o)); // R6

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd_i && !tmo_evt) |=> !tmo_flag_o); // R7

  AST_TMO_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt |=> tmo_flag_o); // R7
endmodule

bind i2c_tgt_autostretch i2c_ast_chk #(.MODE_W(MODE_W), .LVL_W(LVL_W), .DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_i       (mode_i),
  .tx_level_i   (tx_level_i),
  .rx_level_i   (rx_level_i),
  .status_rd_i  (status_rd_i),
  .scl_fall     (scl_fall),
  .tmo_evt      (tmo_evt),
  .st_q         (st_q),
  .scl_low_en_o (scl_low_en_o),
  .tmo_flag_o   (tmo_flag_o)
);

// File: tb/i2c_tgt_autostretch_tb.sv
module i2c_tgt_autostretch_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       scl;
  logic [1:0] phase;
  logic       is_tx;
  logic [1:0] txl, rxl;
  logic [3:0] mode;
  logic       rd;
  logic       en, flag;
  int         total = 0;
  int         fails = 0;
  bit         done  = 1'b0;

  always #10 clk = ~clk;

  i2c_tgt_autostretch u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .phase_i(phase), .is_tx_i(is_tx),
    .tx_level_i(txl), .rx_level_i(rxl), .mode_i(mode), .status_rd_i(rd),
    .scl_low_en_o(en), .tmo_flag_o(flag)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Raise SCL, then drop it; return at the negedge where a hold would first be visible.
  task automatic do_fall();
    scl = 1'b1;
    step(4);
    scl = 1'b0;
    step(3);
  endtask

  task automatic clear_flag();
    rd = 1'b1;
    step(1);
    rd = 1'b0;
  endtask

  function automatic bit exp_trig(input logic [3:0] m, input logic tx,
                                  input logic [1:0] ph, input logic [1:0] tl,
                                  input logic [1:0] rl);
    bit on;
    on = (m != 4'd0) && (m != 4'd15);
    if (tx) return on && (tl == 2'd0) && (ph == 2'd1 || ph == 2'd2);
    return on && (rl >= 2'd2) && (ph == 2'd3);
  endfunction

  function automatic int period(input logic [3:0] m);
    return 1 << (int'(m) + 1);
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; scl = 1'b1; phase = 2'd0; is_tx = 1'b1;
    txl = 2'd1; rxl = 2'd0; mode = 4'd0; rd = 1'b0;
    step(3);
    chk(en == 1'b0 && flag == 1'b0, "R10 reset", {en, flag}, 0);
    rst_n = 1'b1;
    step(2);
    chk(en == 1'b0 && flag == 1'b0, "R10 after reset", {en, flag}, 0);

    // R1: disabled and reserved modes
    txl = 2'd0; phase = 2'd1;
    mode = 4'd0;  do_fall(); step(2);
    chk(en == 1'b0, "R1 mode 0", en, 0);
    mode = 4'd15; do_fall(); step(2);
    chk(en == 1'b0, "R1 mode 15", en, 0);

    // R2/R6/R8/R7: timeout with shortest period
    mode = 4'd1;
    do_fall();
    chk(en == 1'b1, "R2 tx addr-ack hold", en, 1);
    mode = 4'd5; // latched value must stay 1
    step(period(4'd1) - 1);
    chk(en == 1'b1, "R6 still held", en, 1);
    step(1);
    chk(en == 1'b0 && flag == 1'b1, "R6 timeout release", {en, flag}, 2);
    step(5);
    chk(en == 1'b0, "R8 no re-hold", en, 0);
    chk(flag == 1'b1, "R7 flag sticky", flag, 1);
    clear_flag();
    chk(flag == 1'b0, "R7 read clears", flag, 0);
    mode = 4'd1;
    do_fall();
    chk(en == 1'b1, "R8 re-armed on next fall", en, 1);
    txl = 2'd1; step(1);
    chk(en == 1'b0 && flag == 1'b0, "R3 tx release", {en, flag}, 0);

    // R9: release coincides with expiry
    mode = 4'd2; txl = 2'd0; phase = 2'd2;
    do_fall();
    chk(en == 1'b1, "R2 tx data-bits hold", en, 1);
    step(period(4'd2) - 1);
    txl = 2'd2; step(1);
    chk(en == 1'b0 && flag == 1'b0, "R9 coincident release", {en, flag}, 0);

    // R4/R5: receive side, including reserved level 11
    is_tx = 1'b0; mode = 4'd3; phase = 2'd3; rxl = 2'd2;
    do_fall();
    chk(en == 1'b1, "R4 rx full hold", en, 1);
    rxl = 2'd1; step(1);
    chk(en == 1'b0 && flag == 1'b0, "R5 rx release", {en, flag}, 0);
    rxl = 2'd3;
    do_fall();
    chk(en == 1'b1, "R4 rx reserved level counts full", en, 1);
    rxl = 2'd0; step(1);
    chk(en == 1'b0, "R5 rx release from 11", en, 0);
    rxl = 2'd2; phase = 2'd1;
    do_fall(); step(1);
    chk(en == 1'b0, "R4 wrong phase", en, 0);
    is_tx = 1'b1; txl = 2'd0; phase = 2'd3;
    do_fall(); step(1);
    chk(en == 1'b0, "R2 wrong phase", en, 0);
    phase = 2'd0;
    do_fall(); step(1);
    chk(en == 1'b0, "R2 phase other", en, 0);

    // R7: timeout and read on the same edge
    mode = 4'd1; phase = 2'd1;
    do_fall();
    step(period(4'd1) - 1);
    rd = 1'b1; step(1); rd = 1'b0;
    chk(flag == 1'b1, "R7 set wins over read", flag, 1);
    clear_flag();

    // R6: longest period
    mode = 4'd14;
    do_fall();
    step(period(4'd14) - 1);
    chk(en == 1'b1, "R6 long hold", en, 1);
    step(1);
    chk(en == 1'b0 && flag == 1'b1, "R6 long timeout", {en, flag}, 2);
    clear_flag();

    // Random trials
    for (int t = 0; t < 150; t++) begin
      logic [3:0] m;
      bit         e;
      int         l;
      m = 4'($urandom_range(0, 15));
      if (m > 4'd5 && m < 4'd15) m = 4'(int'(m) % 5 + 1);
      mode  = m;
      is_tx = 1'($urandom_range(0, 1));
      phase = 2'($urandom_range(0, 3));
      txl   = 2'($urandom_range(0, 3));
      rxl   = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 1) == 1) begin txl = 2'd0; rxl = 2'd2; end
      e = exp_trig(m, is_tx, phase, txl, rxl);
      do_fall();
      chk(en == e, is_tx ? "R2 random start" : "R4 random start", en, e);
      if (e) begin
        l = period(m);
        if ($urandom_range(0, 1) == 1) begin
          step(l - 1);
          chk(en == 1'b1, "R6 random held", en, 1);
          step(1);
          chk(en == 1'b0 && flag == 1'b1, "R6 random timeout", {en, flag}, 2);
        end else begin
          step($urandom_range(0, l - 1));
          if (is_tx) txl = 2'($urandom_range(1, 3));
          else       rxl = 2'($urandom_range(0, 1));
          step(1);
          chk(en == 1'b0 && flag == 1'b0,
              is_tx ? "R3 random release" : "R5 random release", {en, flag}, 0);
        end
      end else begin
        step(2);
        chk(en == 1'b0 && flag == 1'b0, "R1 random no hold", {en, flag}, 0);
      end
      clear_flag();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule